// File: doc/BRIEF.md
# Packet Payload Burst Mover

This block moves one packet payload at a time between a 32-bit dword stream and memory reached through a Wishbone master. It does not issue one bus cycle per dword, and it does not issue one long unbounded cycle. It cuts the payload into a chain of incrementing-address bursts, each no longer than a configured maximum. Each burst is tagged with the cycle-type codes that let a memory controller prefetch or post ahead. On-chip bus throughput therefore comes much closer to the bus's width-times-clock limit.

A transfer starts with a one-cycle command that carries the following:
- the base byte address;
- the payload length in dwords;
- the direction, which is either stream to memory or memory to stream.

A mode input selects single-dword operation instead of bursting. In that mode every dword gets its own bus cycle, which gives a baseline for comparing throughput. When the transfer ends, the block gives a one-cycle completion pulse with the number of dwords moved and an error flag. A bus error response stops the transfer early.

Top module: `burst_mover`

## Requirements
- R1: After reset the block is idle: `busy`, `wbCyc`, `wbStb`, `doneValid`, `wrReady` and `rdValid` are all low.
- R2: In write direction (`cmdWrite`=1), stream dword i is written to byte address base+4·i, in stream order and unaltered, with `wbWe`=1 and `wbSel`=4'hF.
- R3: When `singleMode`=0, a transfer of L dwords is split into ceil(L/MAX_BURST) bursts. Every burst except the last holds exactly MAX_BURST beats and the last holds the remainder. With the default MAX_BURST=32, a 256-dword transfer is eight bursts of 32.
- R4: Every acknowledged beat is at the address of the previous beat plus 4, within a burst and across bursts. Each burst therefore starts at the previous burst's start plus 4 times its length.
- R5: The final beat of each burst carries `wbCti`=3'b111 and earlier beats carry 3'b010. `wbBte` is always 2'b00. `wbCyc` drops for at least one cycle after each burst ends.
- R6: In read direction (`cmdWrite`=0), the dword at base+4·i appears as the i-th `rdData` accepted with `rdValid` and `rdReady` high.
- R7: With `singleMode`=1 at the command, every dword is its own bus cycle of one beat with `wbCti`=3'b111.
- R8: A command with length 0 issues no bus cycle. It gives `doneValid` two clock edges after the command is sampled, with `doneCount`=0 and `doneErr`=0.
- R9: A stream stall (`wrValid` low, or read data not yet taken) only delays beats. The number of bursts and their lengths stay as in R3.
- R10: A bus error (`wbErr`) on a beat ends the transfer with no further beat. The completion report then has `doneErr`=1 and `doneCount` equal to the beats acknowledged before the error.
- R11: A transfer without an error ends with a `doneValid` pulse one cycle wide, with `doneErr`=0 and `doneCount`=L.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | Start pulse, taken only while idle |
| cmdWrite | input | 1 | 1 = stream to memory, 0 = memory to stream |
| cmdAddr | input | ADDR_W | Base byte address (dword aligned) |
| cmdLen | input | LEN_W | Payload length in dwords |
| singleMode | input | 1 | 1 = one bus cycle per dword |
| busy | output | 1 | A transfer is in progress |
| wrData | input | 32 | Write-direction stream data |
| wrValid | input | 1 | Write stream data present (held until taken) |
| wrReady | output | 1 | Write stream dword taken this cycle |
| rdData | output | 32 | Read-direction stream data |
| rdValid | output | 1 | Read stream data present |
| rdReady | input | 1 | Read stream sink takes data |
| wbCyc | output | 1 | Bus cycle active |
| wbStb | output | 1 | Beat request |
| wbWe | output | 1 | Write enable |
| wbAdr | output | ADDR_W | Byte address |
| wbDatO | output | 32 | Write data |
| wbSel | output | 4 | Byte selects |
| wbCti | output | 3 | Cycle type tag |
| wbBte | output | 2 | Burst type extension |
| wbDatI | input | 32 | Read data |
| wbAck | input | 1 | Beat acknowledge |
| wbErr | input | 1 | Beat error |
| doneValid | output | 1 | One-cycle completion pulse |
| doneErr | output | 1 | Transfer ended on a bus error |
| doneCount | output | LEN_W | Dwords moved |

## Verification
When `cmdStart` is sampled at edge E, `wbCyc` goes high after edge E+1. After the last acknowledge of a burst, `wbCyc` is low for one cycle before the next burst. After the last acknowledge of the transfer, `doneValid` is high during the cycle after the second following edge. After an error, `doneValid` is high during the cycle after the next edge. A zero-length command is checked against that exact two-edge timing at the negative edges in between. Other completions are awaited with a watchdog and then compared field by field. Beats are logged at the clock edge where strobe and acknowledge coincide, and that log is compared with burst lengths, addresses and tags computed in the bench. The stream drivers present and inspect data at the negative edge, so that each handshake is settled before the edge it completes on.

// File: rtl/burst_mover_pkg.sv
package burst_mover_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARM   = 2'd1,
    ST_BURST = 2'd2,
    ST_FIN   = 2'd3
  } moverState_t;

  typedef struct packed {
    logic load;       // capture a new command
    logic beginBurst; // size the next burst
    logic beat;       // a beat was acknowledged
    logic error;      // a beat got an error response
  } moverStrobes_t;

  localparam logic [2:0] CTI_INCR = 3'b010;
  localparam logic [2:0] CTI_END  = 3'b111;
  localparam logic [1:0] BTE_LIN  = 2'b00;

endpackage

// File: rtl/burst_mover_ctrl.sv
module burst_mover_ctrl
  import burst_mover_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          cmdStart,
  input  logic          remZero,
  input  logic          lastBeat,
  input  logic          stbReq,
  input  logic          wbAck,
  input  logic          wbErr,
  output moverStrobes_t strobes,
  output logic          busy,
  output logic          wbCyc,
  output logic          wbStb,
  output logic          doneValid
);

  moverState_t state, stateNext;

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign wbCyc     = (state == ST_BURST);
  assign wbStb     = wbCyc && stbReq;
  assign busy      = (state != ST_IDLE);
  assign doneValid = (state == ST_FIN);

  always_comb begin
    stateNext          = state;
    strobes            = '0;
    strobes.load       = (state == ST_IDLE) && cmdStart;
    strobes.beginBurst = (state == ST_ARM) && !remZero;
    strobes.error      = wbStb && wbErr;
    strobes.beat       = wbStb && wbAck && !wbErr;
    unique case (state)
      ST_IDLE:  if (cmdStart) stateNext = ST_ARM;
      ST_ARM:   stateNext = remZero ? ST_FIN : ST_BURST;
      ST_BURST: begin
        if (strobes.error)                 stateNext = ST_FIN;
        else if (strobes.beat && lastBeat) stateNext = ST_ARM;
      end
      ST_FIN:   stateNext = ST_IDLE;
      default:  stateNext = ST_IDLE;
    endcase
  end

endmodule

// File: rtl/burst_mover_dp.sv
module burst_mover_dp
  import burst_mover_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  moverStrobes_t     strobes,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              singleMode,
  input  logic [31:0]       wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [31:0]       rdData,
  output logic              rdValid,
  input  logic              rdReady,
  input  logic [31:0]       wbDatI,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [31:0]       wbDatO,
  output logic [3:0]        wbSel,
  output logic [2:0]        wbCti,
  output logic [1:0]        wbBte,
  output logic              remZero,
  output logic              lastBeat,
  output logic              stbReq,
  output logic              doneErr,
  output logic [LEN_W-1:0]  doneCount
);

  localparam int BURST_W = $clog2(MAX_BURST + 1);
  localparam logic [LEN_W-1:0] MAX_LEN = LEN_W'(MAX_BURST);

  logic [ADDR_W-1:0]  curAddr;
  logic [LEN_W-1:0]   remLen;
  logic [LEN_W-1:0]   moved;
  logic [BURST_W-1:0] beatsLeft;
  logic               isWrite;
  logic               single;
  logic               errFlag;
  logic [31:0]        rdBuf;
  logic               rdFull;
  logic [LEN_W-1:0]   effMax;
  logic [LEN_W-1:0]   nextBurst;

  assign effMax    = single ? LEN_W'(1) : MAX_LEN;
  assign nextBurst = (remLen < effMax) ? remLen : effMax;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr   <= '0;
      remLen    <= '0;
      moved     <= '0;
      beatsLeft <= '0;
      isWrite   <= 1'b0;
      single    <= 1'b0;
      errFlag   <= 1'b0;
    end else begin
      if (strobes.load) begin
        curAddr <= cmdAddr;
        remLen  <= cmdLen;
        moved   <= '0;
        isWrite <= cmdWrite;
        single  <= singleMode;
        errFlag <= 1'b0;
      end
      if (strobes.beginBurst) beatsLeft <= BURST_W'(nextBurst);
      if (strobes.beat) begin
        curAddr   <= curAddr + ADDR_W'(4);
        remLen    <= remLen - LEN_W'(1);
        moved     <= moved + LEN_W'(1);
        beatsLeft <= beatsLeft - BURST_W'(1);
      end
      if (strobes.error) errFlag <= 1'b1;
    end
  end

  // read-side holding register: one dword between the bus and the stream
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdBuf  <= '0;
      rdFull <= 1'b0;
    end else if (strobes.beat && !isWrite) begin
      rdBuf  <= wbDatI;
      rdFull <= 1'b1;
    end else if (rdReady) begin
      rdFull <= 1'b0;
    end
  end

  assign stbReq   = isWrite ? wrValid : !rdFull;
  assign wrReady  = strobes.beat && isWrite;
  assign rdData   = rdBuf;
  assign rdValid  = rdFull;
  assign remZero  = (remLen == '0);
  assign lastBeat = (beatsLeft == BURST_W'(1));

  assign wbWe   = isWrite;
  assign wbAdr  = curAddr;
  assign wbDatO = wrData;
  assign wbSel  = 4'hF;
  assign wbCti  = lastBeat ? CTI_END : CTI_INCR;
  assign wbBte  = BTE_LIN;

  assign doneErr   = errFlag;
  assign doneCount = moved;

endmodule

// File: rtl/burst_mover.sv
module burst_mover
  import burst_mover_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 16,
  parameter int MAX_BURST = 32
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdWrite,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [LEN_W-1:0]  cmdLen,
  input  logic              singleMode,
  output logic              busy,
  input  logic [31:0]       wrData,
  input  logic              wrValid,
  output logic              wrReady,
  output logic [31:0]       rdData,
  output logic              rdValid,
  input  logic              rdReady,
  output logic              wbCyc,
  output logic              wbStb,
  output logic              wbWe,
  output logic [ADDR_W-1:0] wbAdr,
  output logic [31:0]       wbDatO,
  output logic [3:0]        wbSel,
  output logic [2:0]        wbCti,
  output logic [1:0]        wbBte,
  input  logic [31:0]       wbDatI,
  input  logic              wbAck,
  input  logic              wbErr,
  output logic              doneValid,
  output logic              doneErr,
  output logic [LEN_W-1:0]  doneCount
);

  moverStrobes_t strobes;
  logic remZero, lastBeat, stbReq;

  burst_mover_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart),
    .remZero(remZero), .lastBeat(lastBeat), .stbReq(stbReq),
    .wbAck(wbAck), .wbErr(wbErr), .strobes(strobes),
    .busy(busy), .wbCyc(wbCyc), .wbStb(wbStb), .doneValid(doneValid)
  );

  burst_mover_dp #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAX_BURST)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .cmdWrite(cmdWrite), .cmdAddr(cmdAddr), .cmdLen(cmdLen), .singleMode(singleMode),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .wbDatI(wbDatI), .wbWe(wbWe), .wbAdr(wbAdr), .wbDatO(wbDatO),
    .wbSel(wbSel), .wbCti(wbCti), .wbBte(wbBte),
    .remZero(remZero), .lastBeat(lastBeat), .stbReq(stbReq),
    .doneErr(doneErr), .doneCount(doneCount)
  );

endmodule

// File: rtl/burst_mover_chk.sv
module burst_mover_chk #(
  parameter int ADDR_W    = 32,
  parameter int MAX_BURST = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              cmdStart,
  input logic              busy,
  input logic              wbCyc,
  input logic              wbStb,
  input logic              wbAck,
  input logic              wbErr,
  input logic [ADDR_W-1:0] wbAdr,
  input logic [2:0]        wbCti,
  input logic [1:0]        wbBte,
  input logic              doneValid
);

  localparam int CNT_W = $clog2(MAX_BURST + 1);

  logic [CNT_W-1:0]  beatCnt;
  logic              haveLast;
  logic [ADDR_W-1:0] lastAdr;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      beatCnt  <= '0;
      haveLast <= 1'b0;
      lastAdr  <= '0;
    end else begin
      if (!wbCyc)                        beatCnt <= '0;
      else if (wbStb && wbAck && !wbErr) beatCnt <= beatCnt + CNT_W'(1);
      if (cmdStart && !busy)             haveLast <= 1'b0;
      else if (wbStb && wbAck && !wbErr) begin
        haveLast <= 1'b1;
        lastAdr  <= wbAdr;
      end
    end
  end

  assert_burst_bound_R3: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && wbAck) |-> (beatCnt < CNT_W'(MAX_BURST)));

  assert_addr_step_R4: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && haveLast) |-> (wbAdr == lastAdr + ADDR_W'(4)));

  assert_tag_codes_R5: assert property (@(posedge clk) disable iff (!rstN)
    wbCyc |-> ((wbBte == 2'b00) && (wbCti == 3'b010 || wbCti == 3'b111)));

  assert_burst_close_R5: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && wbAck && wbCti == 3'b111) |=> !wbCyc);

  assert_error_stop_R10: assert property (@(posedge clk) disable iff (!rstN)
    (wbStb && wbErr) |=> (!wbCyc && doneValid));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !wbCyc);

endmodule

bind burst_mover burst_mover_chk #(.ADDR_W(ADDR_W), .MAX_BURST(MAX_BURST)) u_chk (
  .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .busy(busy),
  .wbCyc(wbCyc), .wbStb(wbStb), .wbAck(wbAck), .wbErr(wbErr),
  .wbAdr(wbAdr), .wbCti(wbCti), .wbBte(wbBte), .doneValid(doneValid)
);

// File: tb/test_burst_mover.sv
`timescale 1ns/1ps
module test_burst_mover;

  localparam int ADDR_W = 32;
  localparam int LEN_W  = 16;
  localparam int MAXB   = 32;
  localparam int MEMW   = 1024;
  localparam int MAXLOG = 512;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #4 clk = ~clk;

  logic              cmdStart = 0, cmdWrite = 0, singleMode = 0;
  logic [ADDR_W-1:0] cmdAddr = '0;
  logic [LEN_W-1:0]  cmdLen = '0;
  logic              busy;
  logic [31:0]       wrData = '0;
  logic              wrValid = 0, wrReady;
  logic [31:0]       rdData;
  logic              rdValid, rdReady = 0;
  logic              wbCyc, wbStb, wbWe;
  logic [ADDR_W-1:0] wbAdr;
  logic [31:0]       wbDatO, wbDatI;
  logic [3:0]        wbSel;
  logic [2:0]        wbCti;
  logic [1:0]        wbBte;
  logic              wbAck, wbErr;
  logic              doneValid, doneErr;
  logic [LEN_W-1:0]  doneCount;

  burst_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MAX_BURST(MAXB)) i_burst_mover (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdWrite(cmdWrite),
    .cmdAddr(cmdAddr), .cmdLen(cmdLen), .singleMode(singleMode), .busy(busy),
    .wrData(wrData), .wrValid(wrValid), .wrReady(wrReady),
    .rdData(rdData), .rdValid(rdValid), .rdReady(rdReady),
    .wbCyc(wbCyc), .wbStb(wbStb), .wbWe(wbWe), .wbAdr(wbAdr), .wbDatO(wbDatO),
    .wbSel(wbSel), .wbCti(wbCti), .wbBte(wbBte), .wbDatI(wbDatI),
    .wbAck(wbAck), .wbErr(wbErr),
    .doneValid(doneValid), .doneErr(doneErr), .doneCount(doneCount)
  );

  int checks = 0, errors = 0;
  logic [31:0] mem [MEMW];
  int maxWait = 2;
  int errBeat = -1;
  int waitCnt = 0;
  int slaveBeats = 0;

  // beat log, filled at the edge where a beat completes
  logic [ADDR_W-1:0] logAdr [MAXLOG];
  logic [2:0]        logCti [MAXLOG];
  logic              logWe  [MAXLOG];
  logic [3:0]        logSel [MAXLOG];
  int logN = 0;
  int cycRises = 0;
  logic cycPrev = 0;
  logic [31:0] gotRd [MAXLOG];
  int gotN = 0;
  bit stopStream = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // memory slave: registered ack or err after a random wait
  always @(posedge clk) begin
    wbAck <= 1'b0;
    wbErr <= 1'b0;
    if (!rstN) begin
      waitCnt <= 0;
      wbDatI  <= '0;
    end else begin
      if (cmdStart && !busy) slaveBeats <= 0;
      if (wbCyc && wbStb && !wbAck && !wbErr) begin
        if (waitCnt == 0) begin
          if (slaveBeats == errBeat) wbErr <= 1'b1;
          else begin
            wbAck  <= 1'b1;
            wbDatI <= mem[wbAdr[11:2]];
            if (wbWe) mem[wbAdr[11:2]] <= wbDatO;
            slaveBeats <= slaveBeats + 1;
          end
          waitCnt <= $urandom_range(0, maxWait);
        end else waitCnt <= waitCnt - 1;
      end
    end
  end

  // beat and cycle monitor
  always @(posedge clk) begin
    cycPrev <= wbCyc;
    if (cmdStart && !busy) begin
      logN <= 0;
      cycRises <= 0;
    end else begin
      if (wbCyc && !cycPrev) cycRises <= cycRises + 1;
      if (wbCyc && wbStb && wbAck && !wbErr && logN < MAXLOG) begin
        logAdr[logN] <= wbAdr;
        logCti[logN] <= wbCti;
        logWe[logN]  <= wbWe;
        logSel[logN] <= wbSel;
        logN <= logN + 1;
      end
    end
  end

  function automatic logic [31:0] wrPat(input int tag, input int i);
    return (tag * 32'h9E3779B1) ^ (i * 32'h00010001) ^ 32'h5A00_0000;
  endfunction

  function automatic logic [31:0] memPat(input int k);
    return (k * 32'h01010101) ^ 32'hA5A5_0000;
  endfunction

  function automatic bit isBurstEnd(input int i, input int len, input int maxL);
    return ((i % maxL) == maxL - 1) || (i == len - 1);
  endfunction

  task automatic writer(input int tag, input int len);
    for (int i = 0; i < len && !stopStream; i++) begin
      @(negedge clk);
      wrValid = 1'b0;
      while (($urandom_range(0, 3) == 0) && !stopStream) @(negedge clk);
      wrValid = 1'b1;
      wrData  = wrPat(tag, i);
      #1;
      while (!wrReady && !stopStream) begin
        @(negedge clk);
        #1;
      end
      @(posedge clk);
    end
    @(negedge clk);
    wrValid = 1'b0;
  endtask

  task automatic reader();
    while (!stopStream) begin
      @(negedge clk);
      rdReady = ($urandom_range(0, 3) != 0);
      #1;
      if (rdValid && rdReady && gotN < MAXLOG) begin
        gotRd[gotN] = rdData;
        gotN++;
      end
    end
    rdReady = 1'b0;
  endtask

  task automatic runXfer(input bit wr, input int base, input int len, input bit single,
                         input int errAt, input int tag);
    int dCount, maxL, expBeats, expBursts, badAdr, badCti, badData;
    bit dErr, gotDone;
    maxL = single ? 1 : MAXB;
    errBeat = errAt;
    gotN = 0;
    stopStream = 0;
    gotDone = 0;
    dCount = 0;
    dErr = 0;
    if (!wr) for (int k = 0; k < MEMW; k++) mem[k] = memPat(k);
    @(negedge clk);
    cmdStart = 1; cmdWrite = wr; cmdAddr = ADDR_W'(base * 4);
    cmdLen = LEN_W'(len); singleMode = single;
    @(negedge clk);
    cmdStart = 0;
    fork
      begin
        if (wr) writer(tag, len); else reader();
      end
      begin
        for (int c = 0; c < 20000 && !gotDone; c++) begin
          @(negedge clk);
          if (doneValid) begin
            gotDone = 1;
            dCount = int'(doneCount);
            dErr = doneErr;
          end
        end
        repeat (3) @(negedge clk);
        stopStream = 1;
      end
    join
    check(gotDone, "R11", "done seen before watchdog", gotDone, 1);
    expBeats = (errAt >= 0 && errAt < len) ? errAt : len;
    expBursts = (len + maxL - 1) / maxL;
    if (errAt >= 0 && errAt < len) begin
      check(dErr == 1, "R10", "error flag", dErr, 1);
      check(dCount == expBeats, "R10", "count at error", dCount, expBeats);
      check(logN == expBeats, "R10", "beats logged at error", logN, expBeats);
    end else begin
      check(dErr == 0, "R11", "error flag clear", dErr, 0);
      check(dCount == len, "R11", "done count", dCount, len);
      check(logN == len, "R3", "beats logged", logN, len);
      if (single) check(cycRises == len, "R7", "one bus cycle per dword", cycRises, len);
      else        check(cycRises == expBursts, "R9", "burst count under stalls", cycRises, expBursts);
    end
    badAdr = 0; badCti = 0; badData = 0;
    for (int i = 0; i < logN && i < expBeats; i++) begin
      if (logAdr[i] != ADDR_W'((base + i) * 4)) badAdr++;
      if (logCti[i] != (isBurstEnd(i, len, maxL) ? 3'b111 : 3'b010)) badCti++;
      if (logWe[i] != wr || logSel[i] != 4'hF) badData++;
    end
    check(badAdr == 0, "R4", "address sequence mismatches", badAdr, 0);
    check(badCti == 0, single ? "R7" : "R5", "cycle type mismatches", badCti, 0);
    check(badData == 0, "R2", "we/sel mismatches", badData, 0);
    badData = 0;
    if (wr) begin
      for (int i = 0; i < expBeats; i++) if (mem[base + i] != wrPat(tag, i)) badData++;
      check(badData == 0, "R2", "memory content mismatches", badData, 0);
    end else begin
      check(gotN == expBeats, "R6", "read dwords delivered", gotN, expBeats);
      for (int i = 0; i < gotN && i < expBeats; i++) if (gotRd[i] != memPat(base + i)) badData++;
      check(badData == 0, "R6", "read data mismatches", badData, 0);
    end
  endtask

  initial begin
    process::self().srandom(32'd1234);
    for (int k = 0; k < MEMW; k++) mem[k] = '0;
    repeat (3) @(negedge clk);
    // R1 reset state
    check(!busy && !wbCyc && !wbStb && !doneValid && !wrReady && !rdValid, "R1",
          "idle outputs in reset", {busy, wbCyc, wbStb, doneValid}, 0);
    rstN = 1;
    @(negedge clk);
    check(!busy && !wbCyc && !doneValid, "R1", "idle after reset", {busy, wbCyc, doneValid}, 0);

    // R8 zero length: done exactly two edges after the command edge
    cmdStart = 1; cmdWrite = 1; cmdAddr = 32'h40; cmdLen = 0; singleMode = 0;
    @(negedge clk);
    cmdStart = 0;
    check(!doneValid && !wbCyc, "R8", "no done one edge after zero command", doneValid, 0);
    @(negedge clk);
    check(doneValid && !wbCyc, "R8", "done two edges after zero command", doneValid, 1);
    check(doneCount == 0 && !doneErr, "R8", "zero count", doneCount, 0);
    @(negedge clk);
    check(!doneValid && cycRises == 0, "R8", "no bus cycle for zero length", cycRises, 0);

    // directed: 256 dwords, max 32 -> eight bursts (R3)
    runXfer(1, 16, 256, 0, -1, 1);
    check(cycRises == 8, "R3", "bursts for 256 dwords", cycRises, 8);
    runXfer(0, 300, 256, 0, -1, 2);
    // remainder and boundary lengths
    runXfer(1, 5, 70, 0, -1, 3);
    runXfer(0, 0, 1, 0, -1, 4);
    runXfer(1, 900, 32, 0, -1, 5);
    runXfer(0, 100, 33, 0, -1, 6);
    // single-dword fallback
    runXfer(1, 200, 9, 1, -1, 7);
    runXfer(0, 400, 6, 1, -1, 8);
    // bus error mid-transfer and on the first beat
    runXfer(1, 50, 80, 0, 37, 9);
    runXfer(0, 60, 40, 0, 0, 10);

    // constrained random mix
    for (int n = 0; n < 12; n++) begin
      int len, base;
      len  = $urandom_range(1, 300);
      base = $urandom_range(0, MEMW - len);
      maxWait = $urandom_range(0, 3);
      runXfer($urandom_range(0, 1), base, len, ($urandom_range(0, 4) == 0),
              ($urandom_range(0, 5) == 0) ? $urandom_range(0, len - 1) : -1, 20 + n);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule